// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This unit turns one load operation into the byte address that the memory system should read. The operation carries a mode code, the base and index register values, an immediate, the program counter and the access size. Eight addressing modes are supported: plain register, base plus displacement, base plus index, pointer fetch from memory, post-increment, pre-update with displacement, scaled index with displacement, and PC-relative. The displacement is taken from the low 8 or 16 bits of the immediate, or from all of it, and is sign-extended. The two update modes also return a new base value and a write enable, for the register file to commit.

The pointer-fetch mode takes two memory reads. The unit first reads the word at the base address over a small request/response port. The returned word then becomes the load address. While that read is outstanding the unit drops `op_ready` and ignores new operations.

Before any load goes out, the final address is checked against the access size. A misaligned address produces a one-cycle `misalign` pulse instead of the load, and no base writeback takes place. For a pointer fetch, the pointer read itself must be word aligned.

The control is a three-state machine:
- `ST_IDLE` accepts operations.
- `ST_IDLE` moves to `ST_PTR_SEND` when a pointer-fetch operation with an aligned base is accepted. `ST_PTR_SEND` drives the pointer read for one cycle.
- `ST_PTR_SEND` always moves to `ST_PTR_WAIT`.
- `ST_PTR_WAIT` holds until a response arrives, then returns to `ST_IDLE`.

Top module: `ld_agen`

## Requirements
- R1: After reset `ld_req`, `misalign`, `wb_en` and `ptr_req` are low and `op_ready` is high.
- R2: An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. Its result (`ld_req` or `misalign`) appears in the next cycle. In register mode (`op_mode`=0) the load address equals `base_val` and `wb_en` stays low.
- R3: In displacement mode (`op_mode`=1) the address is `base_val` plus the displacement. `disp_sel`=0 sign-extends `imm_val[7:0]`, `disp_sel`=1 sign-extends `imm_val[15:0]`, and `disp_sel`=2 or 3 uses all 32 bits. Immediate bits above the selected width have no effect.
- R4: In index mode (`op_mode`=2) the address is `base_val + index_val`, computed modulo 2^32.
- R5: In scaled mode (`op_mode`=6) the address is `base_val + index_val*2^scale_sel + displacement`, giving scale factors of 1, 2, 4 or 8.
- R6: In PC-relative mode (`op_mode`=7) the address is `pc_val` plus the displacement.
- R7: In post-increment mode (`op_mode`=4) the address is `base_val`. In the same cycle `wb_en` is high and `wb_val` equals `base_val+1`.
- R8: In pre-update mode (`op_mode`=5) the address is `base_val` plus the displacement. `wb_en` is high and `wb_val` equals that same address.
- R9: In pointer mode (`op_mode`=3), `ptr_req` is high for exactly one cycle, in the cycle after acceptance, with `ptr_addr`=`base_val`. `op_ready` is low from then until a response arrives. A `ptr_rsp_valid` seen while waiting makes the load go out one cycle later, with `ld_addr`=`ptr_rsp_data`. A `ptr_rsp_valid` seen at any other time is ignored.
- R10: `op_size` codes are 0 for byte, 1 for halfword, and 2 or 3 for word. A byte load may use any address. A halfword needs `ld_addr[0]`=0. A word needs `ld_addr[1:0]`=0. `ld_size` repeats the accepted size.
- R11: A misaligned final address makes `misalign` high for one cycle in place of `ld_req`, and `wb_en` stays low. In pointer mode, a `base_val` that is not word aligned also raises `misalign` and issues no pointer read.
- R12: An `op_valid` seen while `op_ready` is low has no effect. It produces no output and does not disturb the pending pointer operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit can accept an operation |
| op_mode | input | 3 | Addressing mode code |
| op_size | input | 2 | Access size code |
| disp_sel | input | 2 | Displacement width select |
| scale_sel | input | 2 | Index shift amount (0..3) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| imm_val | input | 32 | Raw immediate |
| pc_val | input | 32 | Program counter of the load |
| ptr_req | output | 1 | Pointer read request |
| ptr_addr | output | 32 | Pointer read address |
| ptr_rsp_valid | input | 1 | Pointer read data valid |
| ptr_rsp_data | input | 32 | Pointer read data |
| ld_req | output | 1 | Load request, one cycle |
| ld_addr | output | 32 | Load address |
| ld_size | output | 2 | Load size code |
| wb_en | output | 1 | Base register writeback enable |
| wb_val | output | 32 | Base register writeback value |
| misalign | output | 1 | Misaligned access pulse |

## Verification
The bench builds the unit with its defaults: a 32-bit address, and displacement widths of 8 and 16 bits. These defaults put the sign bits at positions 7 and 15, so negative narrow displacements are tested. They also allow address sums that wrap past 2^32, and scale shifts up to 8 that move the index across the alignment bits. With them, each of the three alignment rules is tested on both sides. So are a pointer fetch whose returned word is misaligned, a pointer fetch whose base is misaligned, and operations and responses offered while the unit is busy or idle.

// File: rtl/ld_agen_pkg.sv
package ld_agen_pkg;

    typedef enum logic [2:0] {
        AM_REG_IND  = 3'd0,
        AM_DISP     = 3'd1,
        AM_IDX_BASE = 3'd2,
        AM_MEM_IND  = 3'd3,
        AM_AUTO_INC = 3'd4,
        AM_AUTO_IDX = 3'd5,
        AM_SCALED   = 3'd6,
        AM_PC_REL   = 3'd7
    } amode_t;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_WORD_X = 2'd3
    } asize_t;

    typedef enum logic [1:0] {
        DW_NARROW = 2'd0,
        DW_MID    = 2'd1,
        DW_FULL   = 2'd2,
        DW_FULL_X = 2'd3
    } dwidth_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PTR_SEND = 2'd1,
        ST_PTR_WAIT = 2'd2
    } agen_state_t;

endpackage

// File: rtl/ld_agen_disp.sv
module ld_agen_disp
    import ld_agen_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 8,
    parameter int MID_W    = 16
) (
    input  logic [ADDR_W-1:0] imm_raw,
    input  logic [1:0]        width_sel,
    output logic [ADDR_W-1:0] disp_ext
);
    localparam int NUM_NARROW = 2;

    logic [ADDR_W-1:0] cand [NUM_NARROW+1];

    // one sign extender per narrow width
    for (genvar g = 0; g < NUM_NARROW; g++) begin : g_ext
        localparam int W = (g == 0) ? NARROW_W : MID_W;
        assign cand[g] = {{(ADDR_W-W){imm_raw[W-1]}}, imm_raw[W-1:0]};
    end
    assign cand[NUM_NARROW] = imm_raw;

    always_comb begin
        unique case (dwidth_t'(width_sel))
            DW_NARROW: disp_ext = cand[0];
            DW_MID:    disp_ext = cand[1];
            DW_FULL,
            DW_FULL_X: disp_ext = cand[NUM_NARROW];
            default:   disp_ext = cand[NUM_NARROW];
        endcase
    end
endmodule

// File: rtl/ld_agen_calc.sv
module ld_agen_calc
    import ld_agen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] disp,
    input  logic [1:0]        scale_sh,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_data,
    output logic              indirect
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] scaled_idx;
    logic [ADDR_W-1:0] base_disp;

    assign scaled_idx = index << scale_sh;
    assign base_disp  = base + disp;

    always_comb begin
        ea       = base;
        wb_req   = 1'b0;
        wb_data  = '0;
        indirect = 1'b0;
        unique case (amode_t'(mode))
            AM_REG_IND:  ea = base;
            AM_DISP:     ea = base_disp;
            AM_IDX_BASE: ea = base + index;
            AM_MEM_IND: begin
                ea       = base;
                indirect = 1'b1;
            end
            AM_AUTO_INC: begin
                ea      = base;
                wb_req  = 1'b1;
                wb_data = base + STEP;
            end
            AM_AUTO_IDX: begin
                ea      = base_disp;
                wb_req  = 1'b1;
                wb_data = base_disp;
            end
            AM_SCALED:   ea = base_disp + scaled_idx;
            AM_PC_REL:   ea = pc + disp;
            default:     ea = base;
        endcase
    end
endmodule

// File: rtl/ld_agen_align.sv
module ld_agen_align
    import ld_agen_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       ok
);
    always_comb begin
        unique case (asize_t'(size))
            SZ_BYTE:   ok = 1'b1;
            SZ_HALF:   ok = ~addr_lo[0];
            SZ_WORD,
            SZ_WORD_X: ok = ~|addr_lo;
            default:   ok = ~|addr_lo;
        endcase
    end
endmodule

// File: rtl/ld_agen.sv
module ld_agen
    import ld_agen_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NARROW_W = 8,
    parameter int MID_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [2:0]        op_mode,
    input  logic [1:0]        op_size,
    input  logic [1:0]        disp_sel,
    input  logic [1:0]        scale_sel,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [ADDR_W-1:0] imm_val,
    input  logic [ADDR_W-1:0] pc_val,
    output logic              ptr_req,
    output logic [ADDR_W-1:0] ptr_addr,
    input  logic              ptr_rsp_valid,
    input  logic [ADDR_W-1:0] ptr_rsp_data,
    output logic              ld_req,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [1:0]        ld_size,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_val,
    output logic              misalign
);
    localparam logic [1:0] PTR_SIZE = SZ_WORD;

    agen_state_t state_q, state_d;

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] ea;
    logic              wb_req;
    logic [ADDR_W-1:0] wb_data;
    logic              indirect;
    logic              ea_ok, base_ok, rsp_ok;
    logic              accept;

    logic [ADDR_W-1:0] ptr_addr_q;
    logic [1:0]        size_q;
    logic              ld_req_q, wb_en_q, misalign_q;
    logic [ADDR_W-1:0] ld_addr_q, wb_val_q;
    logic [1:0]        ld_size_q;

    ld_agen_disp #(
        .ADDR_W  (ADDR_W),
        .NARROW_W(NARROW_W),
        .MID_W   (MID_W)
    ) u_disp (
        .imm_raw  (imm_val),
        .width_sel(disp_sel),
        .disp_ext (disp)
    );

    ld_agen_calc #(
        .ADDR_W(ADDR_W)
    ) u_calc (
        .mode    (op_mode),
        .base    (base_val),
        .index   (index_val),
        .pc      (pc_val),
        .disp    (disp),
        .scale_sh(scale_sel),
        .ea      (ea),
        .wb_req  (wb_req),
        .wb_data (wb_data),
        .indirect(indirect)
    );

    ld_agen_align u_ea_chk (
        .addr_lo(ea[1:0]),
        .size   (op_size),
        .ok     (ea_ok)
    );

    ld_agen_align u_ptr_chk (
        .addr_lo(base_val[1:0]),
        .size   (PTR_SIZE),
        .ok     (base_ok)
    );

    ld_agen_align u_rsp_chk (
        .addr_lo(ptr_rsp_data[1:0]),
        .size   (size_q),
        .ok     (rsp_ok)
    );

    assign accept = op_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept && indirect && base_ok) state_d = ST_PTR_SEND;
            ST_PTR_SEND: state_d = ST_PTR_WAIT;
            ST_PTR_WAIT: if (ptr_rsp_valid) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_addr_q <= '0;
            size_q     <= '0;
            ld_req_q   <= 1'b0;
            ld_addr_q  <= '0;
            ld_size_q  <= '0;
            wb_en_q    <= 1'b0;
            wb_val_q   <= '0;
            misalign_q <= 1'b0;
        end else begin
            ld_req_q   <= 1'b0;
            wb_en_q    <= 1'b0;
            misalign_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (indirect) begin
                            if (base_ok) begin
                                ptr_addr_q <= base_val;
                                size_q     <= op_size;
                            end else begin
                                misalign_q <= 1'b1;
                            end
                        end else if (ea_ok) begin
                            ld_req_q  <= 1'b1;
                            ld_addr_q <= ea;
                            ld_size_q <= op_size;
                            wb_en_q   <= wb_req;
                            wb_val_q  <= wb_req ? wb_data : '0;
                        end else begin
                            misalign_q <= 1'b1;
                        end
                    end
                end
                ST_PTR_SEND: begin
                end
                ST_PTR_WAIT: begin
                    if (ptr_rsp_valid) begin
                        if (rsp_ok) begin
                            ld_req_q  <= 1'b1;
                            ld_addr_q <= ptr_rsp_data;
                            ld_size_q <= size_q;
                        end else begin
                            misalign_q <= 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign op_ready = (state_q == ST_IDLE);
    assign ptr_req  = (state_q == ST_PTR_SEND);
    assign ptr_addr = ptr_addr_q;
    assign ld_req   = ld_req_q;
    assign ld_addr  = ld_addr_q;
    assign ld_size  = ld_size_q;
    assign wb_en    = wb_en_q;
    assign wb_val   = wb_val_q;
    assign misalign = misalign_q;

endmodule

// File: rtl/ld_agen_checker.sv
module ld_agen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       op_ready,
    input logic       ptr_req,
    input logic       ld_req,
    input logic [1:0] ld_addr_lo,
    input logic [1:0] ld_size,
    input logic       wb_en,
    input logic       misalign
);
    assert_flag_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!ld_req && !wb_en));

    assert_wb_with_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ld_req);

    assert_ptr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |=> !ptr_req);

    assert_busy_when_ptr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |-> !op_ready);

    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size[1]) |-> (ld_addr_lo == 2'b00));

    assert_half_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size == 2'd1) |-> !ld_addr_lo[0]);
endmodule

bind ld_agen ld_agen_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_ready  (op_ready),
    .ptr_req   (ptr_req),
    .ld_req    (ld_req),
    .ld_addr_lo(ld_addr[1:0]),
    .ld_size   (ld_size),
    .wb_en     (wb_en),
    .misalign  (misalign)
);

// File: tb/ld_agen_bench.sv
module ld_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [2:0]  op_mode = '0;
    logic [1:0]  op_size = '0;
    logic [1:0]  disp_sel = '0;
    logic [1:0]  scale_sel = '0;
    logic [31:0] base_val = '0, index_val = '0, imm_val = '0, pc_val = '0;
    logic        ptr_req;
    logic [31:0] ptr_addr;
    logic        ptr_rsp_valid = 1'b0;
    logic [31:0] ptr_rsp_data = '0;
    logic        ld_req;
    logic [31:0] ld_addr;
    logic [1:0]  ld_size;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        misalign;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // expected items
    bit          q_ld[$];
    logic [31:0] q_addr[$];
    logic [1:0]  q_size[$];
    bit          q_wbe[$];
    logic [31:0] q_wbv[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    ld_agen u_ld_agen (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_mode(op_mode), .op_size(op_size), .disp_sel(disp_sel), .scale_sel(scale_sel),
        .base_val(base_val), .index_val(index_val), .imm_val(imm_val), .pc_val(pc_val),
        .ptr_req(ptr_req), .ptr_addr(ptr_addr), .ptr_rsp_valid(ptr_rsp_valid),
        .ptr_rsp_data(ptr_rsp_data), .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
        .wb_en(wb_en), .wb_val(wb_val), .misalign(misalign)
    );

    function automatic logic [31:0] sx8(input logic [31:0] v);
        return {{24{v[7]}}, v[7:0]};
    endfunction
    function automatic logic [31:0] sx16(input logic [31:0] v);
        return {{16{v[15]}}, v[15:0]};
    endfunction

    task automatic expect_ld(input logic [31:0] a, input logic [1:0] s,
                             input bit we, input logic [31:0] wv, input string tag);
        q_ld.push_back(1'b1); q_addr.push_back(a); q_size.push_back(s);
        q_wbe.push_back(we); q_wbv.push_back(wv); q_tag.push_back(tag);
    endtask

    task automatic expect_mis(input string tag);
        q_ld.push_back(1'b0); q_addr.push_back('0); q_size.push_back('0);
        q_wbe.push_back(1'b0); q_wbv.push_back('0); q_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_op(input logic [2:0] m, input logic [1:0] sz,
                            input logic [31:0] b, input logic [31:0] ix,
                            input logic [31:0] im, input logic [1:0] ds,
                            input logic [1:0] ss, input logic [31:0] pc);
        @(negedge clk);
        op_mode = m; op_size = sz; base_val = b; index_val = ix;
        imm_val = im; disp_sel = ds; scale_sel = ss; pc_val = pc;
        op_valid = 1'b1;
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // pointer-mode sequence with busy-time stimulus
    task automatic ptr_op(input logic [31:0] b, input logic [1:0] sz,
                          input logic [31:0] rsp, input bit rsp_good);
        if (rsp_good) expect_ld(rsp, sz, 1'b0, '0, "R9");
        else          expect_mis("R11");
        drive_op(3'd3, sz, b, '0, '0, 2'd0, 2'd0, '0);
        @(negedge clk);
        check(ptr_req == 1'b1, "R9 ptr_req pulse", {31'd0, ptr_req}, 32'd1);
        check(ptr_addr == b, "R9 ptr_addr", ptr_addr, b);
        check(op_ready == 1'b0, "R9 busy", {31'd0, op_ready}, 32'd0);
        // R12: offer an operation while busy
        op_mode = 3'd0; op_size = 2'd0; base_val = 32'hDEAD_BEE0; op_valid = 1'b1;
        @(negedge clk);
        check(ptr_req == 1'b0, "R9 ptr_req one cycle", {31'd0, ptr_req}, 32'd0);
        check(op_ready == 1'b0, "R12 still busy", {31'd0, op_ready}, 32'd0);
        @(negedge clk);
        ptr_rsp_valid = 1'b1; ptr_rsp_data = rsp;
        @(posedge clk);
        @(negedge clk);
        ptr_rsp_valid = 1'b0; op_valid = 1'b0;
        check(op_ready == 1'b1, "R9 ready after response", {31'd0, op_ready}, 32'd1);
    endtask

    // monitor: pop and compare each result
    always @(negedge clk) begin
        if (rst_n && (ld_req || misalign)) begin
            if (q_ld.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R12 unexpected output actual ld_req=%0b misalign=%0b expected none",
                         ld_req, misalign);
            end else begin
                automatic bit          e_ld  = q_ld.pop_front();
                automatic logic [31:0] e_a   = q_addr.pop_front();
                automatic logic [1:0]  e_s   = q_size.pop_front();
                automatic bit          e_we  = q_wbe.pop_front();
                automatic logic [31:0] e_wv  = q_wbv.pop_front();
                automatic string       e_tag = q_tag.pop_front();
                automatic bit ok = (ld_req == e_ld) && (misalign == !e_ld) && (wb_en == e_we);
                if (e_ld) ok = ok && (ld_addr == e_a) && (ld_size == e_s);
                if (e_we) ok = ok && (wb_val == e_wv);
                nchk++;
                if (!ok) begin
                    nfail++;
                    $display("FAIL %s actual ld=%0b mis=%0b addr=%h size=%0d wbe=%0b wbv=%h expected ld=%0b addr=%h size=%0d wbe=%0b wbv=%h",
                             e_tag, ld_req, misalign, ld_addr, ld_size, wb_en, wb_val,
                             e_ld, e_a, e_s, e_we, e_wv);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!ld_req && !misalign && !wb_en && !ptr_req, "R1 outputs idle",
              {28'd0, ld_req, misalign, wb_en, ptr_req}, 32'd0);
        check(op_ready == 1'b1, "R1 ready", {31'd0, op_ready}, 32'd1);

        // R2 register mode
        expect_ld(32'h1000_0010, 2'd2, 1'b0, '0, "R2");
        drive_op(3'd0, 2'd2, 32'h1000_0010, 32'h55, 32'h7F, 2'd0, 2'd0, '0);
        // R3 displacement widths, back to back
        expect_ld(32'h0000_1FF0, 2'd2, 1'b0, '0, "R3 narrow negative");
        drive_op(3'd1, 2'd2, 32'h0000_2000, '0, 32'h0000_00F0, 2'd0, 2'd0, '0);
        expect_ld(32'h0000_8004, 2'd2, 1'b0, '0, "R3 mid negative wrap");
        drive_op(3'd1, 2'd2, 32'h0001_0000, '0, 32'hABCD_8004, 2'd1, 2'd0, '0);
        expect_ld(32'h0000_1100, 2'd2, 1'b0, '0, "R3 full");
        drive_op(3'd1, 2'd2, 32'h0000_0100, '0, 32'h0000_1000, 2'd2, 2'd0, '0);
        expect_ld(32'h0000_1000 + sx8(32'h0000_0170), 2'd1, 1'b0, '0, "R3 upper bits ignored");
        drive_op(3'd1, 2'd1, 32'h0000_1000, '0, 32'h0000_0170, 2'd0, 2'd0, '0);
        // R4 index
        expect_ld(32'h0000_3024, 2'd2, 1'b0, '0, "R4");
        drive_op(3'd2, 2'd2, 32'h0000_3000, 32'h24, '0, 2'd0, 2'd0, '0);
        expect_ld(32'h0000_0004, 2'd3, 1'b0, '0, "R4 wrap");
        drive_op(3'd2, 2'd3, 32'hFFFF_FFF8, 32'hC, '0, 2'd0, 2'd0, '0);
        // R5 scales
        for (int s = 0; s < 4; s++) begin
            automatic logic [31:0] a = 32'h4000 + (32'd3 << s) + sx8(32'h08) + 32'd1;
            automatic logic [1:0] sz = (s == 0) ? 2'd0 : 2'd0;
            expect_ld(a, sz, 1'b0, '0, "R5");
            drive_op(3'd6, sz, 32'h4001, 32'd3, 32'h08, 2'd0, 2'(s), '0);
        end
        expect_ld(32'h4000 + (32'd5 << 3) + sx16(32'hFFF8), 2'd2, 1'b0, '0, "R5 scale 8 word");
        drive_op(3'd6, 2'd2, 32'h4000, 32'd5, 32'h0000_FFF8, 2'd1, 2'd3, '0);
        // R6 pc relative
        expect_ld(32'h7FFF_FFFC, 2'd2, 1'b0, '0, "R6");
        drive_op(3'd7, 2'd2, 32'h1234_5677, '0, 32'h0000_FFFC, 2'd1, 2'd0, 32'h8000_0000);
        // R7 post increment
        expect_ld(32'h0000_5000, 2'd2, 1'b1, 32'h0000_5001, "R7");
        drive_op(3'd4, 2'd2, 32'h0000_5000, '0, '0, 2'd0, 2'd0, '0);
        // R8 pre update
        expect_ld(32'h0000_5FF8, 2'd2, 1'b1, 32'h0000_5FF8, "R8");
        drive_op(3'd5, 2'd2, 32'h0000_6000, '0, 32'h0000_00F8, 2'd0, 2'd0, '0);
        // R10 alignment rules
        expect_ld(32'h0000_7001, 2'd0, 1'b0, '0, "R10 byte odd");
        drive_op(3'd1, 2'd0, 32'h0000_7001, '0, '0, 2'd2, 2'd0, '0);
        expect_mis("R10 half odd");
        drive_op(3'd1, 2'd1, 32'h0000_7001, '0, '0, 2'd2, 2'd0, '0);
        expect_ld(32'h0000_7002, 2'd1, 1'b0, '0, "R10 half even");
        drive_op(3'd1, 2'd1, 32'h0000_7002, '0, '0, 2'd2, 2'd0, '0);
        expect_mis("R10 word offset two");
        drive_op(3'd1, 2'd2, 32'h0000_7002, '0, '0, 2'd2, 2'd0, '0);
        // R11 misaligned update mode suppresses writeback
        expect_mis("R11 no writeback");
        drive_op(3'd4, 2'd2, 32'h0000_5002, '0, '0, 2'd0, 2'd0, '0);
        go_idle();
        @(negedge clk);
        check(!ld_req && !misalign, "R11 single cycle pulse",
              {30'd0, ld_req, misalign}, 32'd0);

        // R9 pointer mode
        ptr_op(32'h0000_9000, 2'd2, 32'hA000_0040, 1'b1);
        ptr_op(32'h0000_9010, 2'd1, 32'hA000_0041, 1'b0);
        // R11 misaligned pointer base
        expect_mis("R11 pointer base");
        drive_op(3'd3, 2'd0, 32'h0000_9002, '0, '0, 2'd0, 2'd0, '0);
        go_idle();
        check(ptr_req == 1'b0, "R11 no pointer read", {31'd0, ptr_req}, 32'd0);
        check(op_ready == 1'b1, "R11 stays ready", {31'd0, op_ready}, 32'd1);
        // R9 stray response while idle is ignored
        @(negedge clk);
        ptr_rsp_valid = 1'b1; ptr_rsp_data = 32'h0000_0100;
        @(negedge clk);
        ptr_rsp_valid = 1'b0;
        check(!ld_req && !misalign, "R9 stray response ignored",
              {30'd0, ld_req, misalign}, 32'd0);
        @(negedge clk);
        check(!ld_req && !misalign && op_ready, "R9 idle after stray response",
              {29'd0, ld_req, misalign, op_ready}, 32'd1);

        repeat (3) @(negedge clk);
        check(q_ld.size() == 0, "R12 all expected results seen",
              q_ld.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule